// File: doc/BRIEF.md
# Dual-Rate Channel Scan Sequencer

This block walks through a set of measurement channels and requests one conversion at a time from an external converter. Every channel can be placed in a regular-rate mask or a low-rate mask. Regular channels are converted on every pass. Low-rate channels join a pass only when an internal pass counter is zero. That counter wraps after 1, 4, 16 or 64 passes, and a configuration field selects which. When a pass includes low-rate channels, they are merged with the regular ones into a single ascending channel order.

For each channel the sequencer presents the channel index with a one-cycle convert strobe. It then waits for the converter's done input before moving on. An end-of-sequence pulse marks the end of a pass, and a selector decides which kinds of pass produce it. A 16-bit configuration word holds the rate and end-of-sequence fields and four range-select bits, which are passed straight to an output. Scanning runs while `scan_en` is high. When `scan_en` is dropped, the current pass finishes and the block goes idle.

Top module: `scan_seq_top`

## Requirements
- R1: The configuration word is 16 bits and resets to 0x0000. A write stores all 16 bits, `cfg_rd` returns the stored word on the next cycle, and `range_sel` equals bits 3:0 of the word.
- R2: In each pass the enabled channels are converted in ascending index order, each exactly once. Each conversion is one `conv_stb` cycle with `ch_idx` valid. No further strobe is issued until `conv_done` has been seen for the outstanding channel.
- R3: The rate field is bits 9:8, and the pass counter wraps at N = 1, 4, 16 or 64 for codes 00, 01, 10 or 11. Low-rate channels are included only in passes where the counter is 0, so with code 00 they are in every pass.
- R4: The end-of-sequence select is bits 11:10. Code 01 pulses `eos` after passes that include low-rate channels. Code 10 pulses after every pass. Codes 00 and 11 pulse only after passes that do not include low-rate channels.
- R5: `eos` is high for exactly one cycle: the cycle after the clock edge that accepts the last `conv_done` of the pass.
- R6: A channel set in both masks is converted once, as a regular channel. `cfg_err` is then set at the start of that pass and stays high until reset.
- R7: A pass with no enabled channels finishes with no strobe. It still advances the pass counter and applies the end-of-sequence policy.
- R8: Mask inputs are sampled only at the start of a pass, so a change during a pass first affects the next pass.
- R9: A configuration write clears the pass counter at the next pass boundary, so the next pass to start includes low-rate channels.
- R10: With `scan_en` low at the end of a pass, the block goes idle (`busy` low) and clears the pass counter. The next scan after idle begins with a pass that includes low-rate channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_en | input | 1 | Keep scanning while high |
| reg_mask | input | NCH | Regular-rate channel enables |
| slow_mask | input | NCH | Low-rate channel enables |
| conv_done | input | 1 | Converter finished the strobed channel |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write data |
| ch_idx | output | $clog2(NCH) | Channel being converted |
| conv_stb | output | 1 | One-cycle start-conversion strobe |
| eos | output | 1 | End-of-sequence pulse |
| busy | output | 1 | Sequencer not idle |
| cfg_err | output | 1 | Sticky mask-overlap flag |
| cfg_rd | output | 16 | Stored configuration word |
| range_sel | output | 4 | Per-channel range selects |

## Verification
Two kinds of mask pattern are used. Interleaved regular and low-rate channels show that the merge keeps ascending order. A single regular and a single low-rate channel make the divided inclusion period countable for every rate code. For each end-of-sequence code, the position of the `eos` markers in the observed stream tells the policy apart: after passes with low-rate channels, after passes without them, or after every pass. Further cases check that empty masks still advance the counter and that overlapping masks are not converted twice. Mask and configuration changes made during a pass show whether they took effect at the right pass boundary.

// File: rtl/scan_pkg.sv
package scan_pkg;

    localparam int CFG_W     = 16;
    localparam int RANGE_W   = 4;
    localparam int RATE_LSB  = 8;
    localparam int EOSSEL_LSB = 10;
    localparam int PASS_CW   = 6;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_SEEK = 2'd2,
        ST_WAIT = 2'd3
    } seq_st_e;

    // decide whether a finished pass raises end-of-sequence
    function automatic logic eos_fire(input logic [1:0] sel, input logic slow_pass);
        logic r;
        case (sel)
            2'b01:   r = slow_pass;
            2'b10:   r = 1'b1;
            default: r = ~slow_pass;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/scan_cfg_reg.sv
module scan_cfg_reg
    import scan_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [CFG_W-1:0]   wdata,
    output logic [CFG_W-1:0]   word,
    output logic [1:0]         rate,
    output logic [1:0]         eos_sel,
    output logic [RANGE_W-1:0] range_sel
);
    logic [CFG_W-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (we) word_d = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    assign word      = word_q;
    assign rate      = word_q[RATE_LSB +: 2];
    assign eos_sel   = word_q[EOSSEL_LSB +: 2];
    assign range_sel = word_q[RANGE_W-1:0];
endmodule

// File: rtl/scan_pick.sv
module scan_pick #(
    parameter int NCH = 8,
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0] req,
    output logic           found,
    output logic [IW-1:0]  idx
);
    // lowest set bit wins: scan downward so the last hit is the smallest index
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/scan_pass_ctr.sv
module scan_pass_ctr
    import scan_pkg::*;
#(
    parameter int CW = PASS_CW
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       adv,
    input  logic [1:0] rate,
    output logic       is_zero
);
    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] wrap_mask;

    always_comb begin
        wrap_mask = CW'((7'd1 << {rate, 1'b0}) - 7'd1);
        cnt_d     = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (adv)
            cnt_d = (cnt_q + CW'(1)) & wrap_mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign is_zero = (cnt_q == '0);
endmodule

// File: rtl/scan_seq_top.sv
module scan_seq_top
    import scan_pkg::*;
#(
    parameter int NCH = 8,
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scan_en,
    input  logic [NCH-1:0]     reg_mask,
    input  logic [NCH-1:0]     slow_mask,
    input  logic               conv_done,
    input  logic               cfg_we,
    input  logic [CFG_W-1:0]   cfg_wdata,
    output logic [IW-1:0]      ch_idx,
    output logic               conv_stb,
    output logic               eos,
    output logic               busy,
    output logic               cfg_err,
    output logic [CFG_W-1:0]   cfg_rd,
    output logic [RANGE_W-1:0] range_sel
);
    typedef struct packed {
        seq_st_e        st;
        logic [NCH-1:0] todo;
        logic           slow_pass;
        logic           pend;
        logic [IW-1:0]  idx;
        logic           stb;
        logic           eos;
        logic           err;
    } seq_s;

    seq_s s_d, s_q;

    logic [1:0]    rate, eos_sel;
    logic          ctr_zero, ctr_clr, ctr_adv;
    logic          pick_found;
    logic [IW-1:0] pick_idx;
    logic          incl, end_pass;

    scan_cfg_reg cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .wdata     (cfg_wdata),
        .word      (cfg_rd),
        .rate      (rate),
        .eos_sel   (eos_sel),
        .range_sel (range_sel)
    );

    scan_pass_ctr #(.CW(PASS_CW)) ctr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (ctr_clr),
        .adv     (ctr_adv),
        .rate    (rate),
        .is_zero (ctr_zero)
    );

    scan_pick #(.NCH(NCH)) pick_i (
        .req   (s_q.todo),
        .found (pick_found),
        .idx   (pick_idx)
    );

    always_comb begin
        s_d      = s_q;
        s_d.stb  = 1'b0;
        s_d.eos  = 1'b0;
        ctr_clr  = 1'b0;
        ctr_adv  = 1'b0;
        end_pass = 1'b0;
        // a pending write clears the counter, so that pass counts as counter zero
        incl     = (rate == 2'b00) || s_q.pend || ctr_zero;

        case (s_q.st)
            ST_IDLE: begin
                ctr_clr  = 1'b1;
                s_d.pend = 1'b0;
                if (scan_en) s_d.st = ST_LOAD;
            end
            ST_LOAD: begin
                s_d.todo      = reg_mask | (incl ? (slow_mask & ~reg_mask) : '0);
                s_d.slow_pass = incl;
                ctr_clr       = s_q.pend;
                s_d.pend      = 1'b0;
                if (|(reg_mask & slow_mask)) s_d.err = 1'b1;
                s_d.st        = ST_SEEK;
            end
            ST_SEEK: begin
                if (pick_found) begin
                    s_d.idx            = pick_idx;
                    s_d.stb            = 1'b1;
                    s_d.todo[pick_idx] = 1'b0;
                    s_d.st             = ST_WAIT;
                end else begin
                    end_pass = 1'b1;
                end
            end
            ST_WAIT: begin
                if (conv_done) begin
                    if (s_q.todo == '0) end_pass = 1'b1;
                    else                s_d.st   = ST_SEEK;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase

        if (end_pass) begin
            s_d.eos = eos_fire(eos_sel, s_q.slow_pass);
            ctr_adv = 1'b1;
            s_d.st  = scan_en ? ST_LOAD : ST_IDLE;
        end

        if (cfg_we) s_d.pend = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st        <= ST_IDLE;
            s_q.todo      <= '0;
            s_q.slow_pass <= 1'b0;
            s_q.pend      <= 1'b0;
            s_q.idx       <= '0;
            s_q.stb       <= 1'b0;
            s_q.eos       <= 1'b0;
            s_q.err       <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ch_idx   = s_q.idx;
    assign conv_stb = s_q.stb;
    assign eos      = s_q.eos;
    assign busy     = (s_q.st != ST_IDLE);
    assign cfg_err  = s_q.err;
endmodule

// File: rtl/scan_seq_chk.sv
module scan_seq_chk
    import scan_pkg::*;
#(
    parameter int NCH = 8,
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [CFG_W-1:0] cfg_wdata,
    input logic [CFG_W-1:0] cfg_rd,
    input logic [IW-1:0]    ch_idx,
    input logic             conv_stb,
    input logic             eos,
    input logic             busy,
    input logic             cfg_err
);
    // R1
    cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_we) && $past(rst_n)) |-> (cfg_rd == $past(cfg_wdata)));

    // R2
    stb_in_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_stb |-> busy);

    // R2
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_stb |=> !conv_stb);

    // R5
    eos_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eos |=> !eos);

    // R5
    stb_eos_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(conv_stb && eos));

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(cfg_err));
endmodule

bind scan_seq_top scan_seq_chk #(.NCH(NCH)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rd    (cfg_rd),
    .ch_idx    (ch_idx),
    .conv_stb  (conv_stb),
    .eos       (eos),
    .busy      (busy),
    .cfg_err   (cfg_err)
);

// File: tb/scan_seq_tb.sv
module scan_seq_top_tb_top;
    localparam int NCH = 8;
    localparam int EV_EOS = 99;
    localparam int MAXEV = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scan_en = 1'b0;
    logic [7:0]  reg_mask = '0;
    logic [7:0]  slow_mask = '0;
    logic        conv_done = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [2:0]  ch_idx;
    logic        conv_stb, eos, busy, cfg_err;
    logic [15:0] cfg_rd;
    logic [3:0]  range_sel;

    int checks = 0;
    int fails = 0;
    int obs[MAXEV];
    int obs_n = 0;
    int expv[MAXEV];
    int exp_n = 0;

    always #4 clk = ~clk;

    scan_seq_top #(.NCH(NCH)) dut_i (
        .clk(clk), .rst_n(rst_n), .scan_en(scan_en),
        .reg_mask(reg_mask), .slow_mask(slow_mask), .conv_done(conv_done),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .ch_idx(ch_idx), .conv_stb(conv_stb), .eos(eos), .busy(busy),
        .cfg_err(cfg_err), .cfg_rd(cfg_rd), .range_sel(range_sel)
    );

    task automatic chk(input string req, input int got, input int want);
        checks++;
        if (got != want) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, want);
        end
    endtask

    task automatic chk_stream(input string req);
        int bad = -1;
        checks++;
        for (int i = 0; i < exp_n && i < obs_n; i++)
            if (bad < 0 && obs[i] != expv[i]) bad = i;
        if (obs_n != exp_n && bad < 0) bad = (obs_n < exp_n) ? obs_n : exp_n;
        if (bad >= 0) begin
            fails++;
            $display("FAIL %s: event %0d got %0d expected %0d (lengths %0d/%0d)", req, bad,
                     (bad < obs_n) ? obs[bad] : -1, (bad < exp_n) ? expv[bad] : -1, obs_n, exp_n);
        end
    endtask

    task automatic push_exp(input int v);
        if (exp_n < MAXEV) begin expv[exp_n] = v; exp_n++; end
    endtask

    task automatic push_obs(input int v);
        if (obs_n < MAXEV) begin obs[obs_n] = v; obs_n++; end
    endtask

    // expected event stream from the requirements, starting at pass counter zero
    task automatic build(input logic [7:0] rm, input logic [7:0] sm, input int rate,
                         input int sel, input int n_eos);
        int pc = 0;
        int e = 0;
        int n = 1 << (2 * rate);
        int guard = 0;
        logic incl, fire;
        logic [7:0] act;
        exp_n = 0;
        while (e < n_eos && guard < 400) begin
            incl = (rate == 0) || (pc == 0);
            act  = rm | (incl ? (sm & ~rm) : 8'h00);
            for (int c = 0; c < 8; c++) if (act[c]) push_exp(c);
            fire = (sel == 1) ? incl : (sel == 2) ? 1'b1 : !incl;
            if (fire) begin push_exp(EV_EOS); e++; end
            pc = (pc + 1) % n;
            guard++;
        end
    endtask

    // answer conversions and log events; stop after n_eos pulses, or when idle if drain
    task automatic serve(input int n_eos, input bit drain);
        int seen = 0;
        int guard = 0;
        while (1) begin
            @(negedge clk);
            conv_done = 1'b0;
            if (conv_stb) begin push_obs(int'(ch_idx)); conv_done = 1'b1; end
            if (eos) begin push_obs(EV_EOS); seen++; end
            guard++;
            if (drain ? !busy : (seen >= n_eos)) break;
            if (guard > 5000) begin
                checks++; fails++;
                $display("FAIL watchdog: serve hung got %0d expected %0d", seen, n_eos);
                break;
            end
        end
    endtask

    task automatic write_cfg(input logic [15:0] w);
        cfg_we = 1'b1; cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic start_scan(input logic [7:0] rm, input logic [7:0] sm, input logic [15:0] w);
        scan_en = 1'b0;
        serve(0, 1'b1);
        write_cfg(w);
        reg_mask = rm; slow_mask = sm;
        obs_n = 0;
        scan_en = 1'b1;
    endtask

    task automatic do_reset();
        scan_en = 1'b0; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 reset cfg_rd", int'(cfg_rd), 0);
        chk("R1 reset range_sel", int'(range_sel), 0);
        chk("R10 reset busy", int'(busy), 0);
        chk("R2 reset conv_stb", int'(conv_stb), 0);
        chk("R6 reset cfg_err", int'(cfg_err), 0);
    endtask

    task automatic t_cfg();
        write_cfg(16'hF6AB);
        chk("R1 readback", int'(cfg_rd), 16'hF6AB);
        chk("R1 range_sel", int'(range_sel), 4'hB);
        write_cfg(16'h0000);
        chk("R1 readback zero", int'(cfg_rd), 0);
    endtask

    task automatic run_case(input string req, input logic [7:0] rm, input logic [7:0] sm,
                            input int rate, input int sel, input int n_eos);
        start_scan(rm, sm, 16'((sel << 10) | (rate << 8)));
        serve(n_eos, 1'b0);
        scan_en = 1'b0;
        build(rm, sm, rate, sel, n_eos);
        chk_stream(req);
    endtask

    task automatic t_wait_and_eos();
        int gap = 0;
        start_scan(8'h06, 8'h00, 16'h0800);
        while (!conv_stb && gap < 50) begin @(negedge clk); gap++; end
        chk("R2 first idx", int'(ch_idx), 1);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk("R2 no strobe while waiting", int'(conv_stb | eos), 0);
        end
        conv_done = 1'b1;
        @(negedge clk); conv_done = 1'b0;
        chk("R2 no early strobe", int'(conv_stb), 0);
        @(negedge clk);
        chk("R2 next strobe", int'(conv_stb), 1);
        chk("R2 next idx", int'(ch_idx), 2);
        conv_done = 1'b1;
        @(negedge clk); conv_done = 1'b0;
        chk("R5 eos after last done", int'(eos), 1);
        @(negedge clk);
        chk("R5 eos one cycle", int'(eos), 0);
        scan_en = 1'b0;
    endtask

    task automatic t_overlap();
        run_case("R6 overlap order", 8'h05, 8'h0C, 0, 2, 2);
        exp_n = 0;
        push_exp(0); push_exp(2); push_exp(3); push_exp(EV_EOS);
        push_exp(0); push_exp(2); push_exp(3); push_exp(EV_EOS);
        chk_stream("R6 overlap converted once");
        chk("R6 err set", int'(cfg_err), 1);
        run_case("R6 clean masks", 8'h01, 8'h02, 0, 2, 1);
        chk("R6 err sticky", int'(cfg_err), 1);
        do_reset();
        chk("R6 err cleared by reset", int'(cfg_err), 0);
    endtask

    task automatic t_mask_mid();
        int g = 0;
        start_scan(8'h03, 8'h00, 16'h0800);
        serve(1, 1'b0);
        while (g < 50) begin
            @(negedge clk);
            conv_done = 1'b0;
            g++;
            if (conv_stb) begin
                push_obs(int'(ch_idx));
                conv_done = 1'b1;
                reg_mask = 8'h30;
                break;
            end
        end
        serve(2, 1'b0);
        scan_en = 1'b0;
        exp_n = 0;
        push_exp(0); push_exp(1); push_exp(EV_EOS);
        push_exp(0); push_exp(1); push_exp(EV_EOS);
        push_exp(4); push_exp(5); push_exp(EV_EOS);
        chk_stream("R8 masks change at boundary");
    endtask

    task automatic t_rate_write();
        start_scan(8'h01, 8'h80, 16'h0900);
        serve(2, 1'b0);
        write_cfg(16'h0900);
        serve(2, 1'b0);
        scan_en = 1'b0;
        exp_n = 0;
        push_exp(0); push_exp(7); push_exp(EV_EOS);
        push_exp(0); push_exp(EV_EOS);
        push_exp(0); push_exp(EV_EOS);
        push_exp(0); push_exp(7); push_exp(EV_EOS);
        chk_stream("R9 write clears pass counter");
    endtask

    task automatic t_stop();
        start_scan(8'h01, 8'h02, 16'h0900);
        serve(2, 1'b0);
        scan_en = 1'b0;
        serve(0, 1'b1);
        chk("R10 idle after stop", int'(busy), 0);
        obs_n = 0;
        scan_en = 1'b1;
        serve(1, 1'b0);
        scan_en = 1'b0;
        exp_n = 0;
        push_exp(0); push_exp(1); push_exp(EV_EOS);
        chk_stream("R10 restart at counter zero");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: global timeout");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_cfg();
        // R2 R3: merged ascending order with low-rate in every pass
        run_case("R2 merged ascending order", 8'h81, 8'h14, 0, 2, 2);
        // R3 R4: divided inclusion, eos only on low-rate passes
        run_case("R3 rate every 4th, R4 sel 01", 8'h02, 8'h10, 1, 1, 2);
        run_case("R3 rate every 16th", 8'h01, 8'h02, 2, 1, 2);
        run_case("R3 rate every 64th", 8'h01, 8'h02, 3, 1, 2);
        run_case("R4 sel 00 regular passes", 8'h02, 8'h10, 1, 0, 3);
        run_case("R4 sel 11 like 00", 8'h02, 8'h10, 1, 3, 3);
        run_case("R4 sel 10 every pass", 8'h01, 8'h02, 1, 2, 5);
        t_wait_and_eos();
        t_overlap();
        run_case("R7 empty passes", 8'h00, 8'h00, 0, 2, 3);
        run_case("R7 empty passes advance counter", 8'h00, 8'h08, 1, 1, 2);
        t_mask_mid();
        t_rate_write();
        t_stop();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule